// File: doc/BRIEF.md
# Two-Pin Edge-Aligned PWM Generator

The block derives two pulse-width-modulated outputs, A and B, from one up-counting timebase. Both pins share a single period, and each pin has its own compare value. The timebase counts from zero to the period minus one and then wraps. At each wrap a pin rises. When the count reaches that pin's compare value, the pin falls.

Software configures the block through a one-cycle write port. Period and duty writes go into buffer registers. The counter moves them into its working copies only when it starts or wraps, so a change never breaks a cycle that is already running. The expected way to reconfigure is: stop, write the period, write each duty value, then start. Each pin has three settings. An output enable. A stop level, which is the level the pin holds while the timer is halted or its enable is clear. An invert flag, which turns a requested pulse width into a compare value measured back from the end of the period.

A parameter selects a 16-bit or a 32-bit counter. If a write carries a value the counter cannot hold, or names a pin that does not exist, the block refuses the write and raises an error pulse.

Top module: `pwm_edge_gen`

## Requirements
- R1: While the timer runs with output enable set, a pin is high for C clock cycles, counted from each wrap, and low for the rest of a P-cycle period. P is the active period and C is the active compare value, with 0 < C < P.
- R2: A period value of 0 selects the full counter range: P = 2^N, where N is 16 or 32.
- R3: With a compare value of 0 the pin stays low for the whole period. With a compare value at or above P the pin stays high for the whole period.
- R4: Period and duty writes are buffered. The cycle in progress completes with the old values, and the new values apply from the next wrap onward. A start also loads the buffered values.
- R5: When a pin's invert flag is set at the time a duty value is written, the stored compare value is P − pulse, and it saturates at 0. P comes from the buffered period.
- R6: In 16-bit mode, a period or duty value above 65535 is refused. The write raises wr_err for one cycle and changes nothing.
- R7: The pin select wr_chan takes the value 0 for A and 1 for B. A duty or pin-config write with wr_chan equal to 2 or 3 is refused. It raises wr_err for one cycle and changes nothing.
- R8: While the timer is stopped, or while the pin's output enable is clear, the pin drives its stop level. After reset every stop level is 0 and the timer is stopped.
- R9: Command writes use address 0: bit 0 starts the timer and bit 1 stops it. Stop takes priority over start. Stop clears the count, and a later start begins a new period at count 0. A start while the timer is running has no effect.
- R10: Register addresses: 1 is the period and ignores wr_chan; 2 is the duty of pin wr_chan; 3 is the config of pin wr_chan, with bit 0 as output enable, bit 1 as stop level and bit 2 as invert. In 32-bit mode, values above 65535 are accepted without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 2 | Register address |
| wr_chan | input | 2 | Pin select for per-pin registers |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | One-cycle pulse marking a refused write |
| pwm_a | output | 1 | PWM output A, registered |
| pwm_b | output | 1 | PWM output B, registered |

## Verification
Most internal faults show up as a wrong pulse shape within one or two periods. A bad working compare value changes the measured high width. A bad period copy or a bad wrap point changes the spacing between rising edges. Faults in the shadow logic are exposed by writes made in the middle of a cycle: a value taken too early corrupts the cycle that was already running, and a value never taken leaves the following cycle wrong. A refused write that still leaked into a buffer would show one wrap later, as a changed width or spacing on the pins, so the bench measures the pins again after every rejected write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NPIN = 2;

  localparam logic [1:0] ADR_CMD    = 2'd0;
  localparam logic [1:0] ADR_PERIOD = 2'd1;
  localparam logic [1:0] ADR_DUTY   = 2'd2;
  localparam logic [1:0] ADR_PINCFG = 2'd3;

  typedef struct packed {
    logic inv;
    logic stop_lvl;
    logic oe;
  } pin_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_addr,
  input  logic [1:0]                  wr_chan,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [CNT_W-1:0]            per_buf,
  output logic [NPIN-1:0][CNT_W:0]    cmp_buf,
  output pin_cfg_t [NPIN-1:0]         cfg,
  output logic                        start_req,
  output logic                        stop_req,
  output logic                        wr_err
);
  localparam logic [DATA_W:0] MAXV = (DATA_W+1)'((64'd1 << CNT_W) - 64'd1);
  localparam logic [CNT_W:0]  FULL = (CNT_W+1)'(64'd1 << CNT_W);

  logic            chan_ok, val_bad, reject;
  logic [CNT_W:0]  full_per, pulse, inv_cmp, new_cmp;

  assign chan_ok = (int'(wr_chan) < NPIN);
  assign val_bad = ({1'b0, wr_data} > MAXV);

  always_comb begin
    reject = 1'b0;
    case (wr_addr)
      ADR_PERIOD: reject = val_bad;
      ADR_DUTY:   reject = val_bad || !chan_ok;
      ADR_PINCFG: reject = !chan_ok;
      default:    reject = 1'b0;
    endcase
  end

  // effective period of the buffered value and inverted compare
  assign full_per = (per_buf == '0) ? FULL : {1'b0, per_buf};
  assign pulse    = {1'b0, wr_data[CNT_W-1:0]};
  assign inv_cmp  = (full_per > pulse) ? (full_per - pulse) : '0;
  assign new_cmp  = cfg[wr_chan[0]].inv ? inv_cmp : pulse;

  assign start_req = wr_en && (wr_addr == ADR_CMD) && wr_data[0];
  assign stop_req  = wr_en && (wr_addr == ADR_CMD) && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf <= '0;
      cmp_buf <= '0;
      cfg     <= '0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= wr_en && reject;
      if (wr_en && !reject) begin
        case (wr_addr)
          ADR_PERIOD: per_buf <= wr_data[CNT_W-1:0];
          ADR_DUTY:   cmp_buf[wr_chan[0]] <= new_cmp;
          ADR_PINCFG: cfg[wr_chan[0]] <= pin_cfg_t'(wr_data[2:0]);
          default: ;
        endcase
      end
    end
  end

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en)); // R6
  AST_REJECT_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_PERIOD && val_bad) |=> $stable(per_buf)); // R6
  AST_BADCHAN_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !chan_ok) |=> ($stable(cfg) && $stable(cmp_buf))); // R7
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_req,
  input  logic                     stop_req,
  input  logic [CNT_W-1:0]         per_buf,
  input  logic [NPIN-1:0][CNT_W:0] cmp_buf,
  output logic                     running,
  output logic [CNT_W-1:0]         cnt,
  output logic [NPIN-1:0][CNT_W:0] cmp_act
);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(64'd1 << CNT_W);

  logic [CNT_W-1:0] per_act;
  logic [CNT_W:0]   full_act;
  logic             last;

  assign full_act = (per_act == '0) ? FULL : {1'b0, per_act};
  assign last     = ({1'b0, cnt} == (full_act - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      per_act <= '0;
      cmp_act <= '0;
    end else if (stop_req) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start_req && !running) begin
      running <= 1'b1;
      cnt     <= '0;
      per_act <= per_buf;
      cmp_act <= cmp_buf;
    end else if (running) begin
      if (last) begin
        cnt     <= '0;
        per_act <= per_buf;
        cmp_act <= cmp_buf;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    running |-> ({1'b0, cnt} < full_act)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !last && !stop_req) |=> ($stable(per_act) && $stable(cmp_act))); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (running && last) |=> (cnt == '0)); // R1
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (!running && cnt == '0)); // R9
endmodule

// File: rtl/pwm_pin_out.sv
module pwm_pin_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   cmp_act,
  input  logic             oe,
  input  logic             stop_lvl,
  output logic             pin
);
  always_ff @(posedge clk) begin
    if (rst)                   pin <= 1'b0;
    else if (running && oe)    pin <= ({1'b0, cnt} < cmp_act);
    else                       pin <= stop_lvl;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!running || !oe) |=> (pin == $past(stop_lvl))); // R8
  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (running && oe && cmp_act == '0) |=> !pin); // R3
  AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (running && oe && cnt == '0 && cmp_act != '0) |=> pin); // R1
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_pkg::*;
#(
  parameter bit WIDE_CNT = 1'b0,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [1:0]        wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int CNT_W = WIDE_CNT ? 32 : 16;

  logic [CNT_W-1:0]         per_buf;
  logic [NPIN-1:0][CNT_W:0] cmp_buf, cmp_act;
  pin_cfg_t [NPIN-1:0]      cfg;
  logic                     start_req, stop_req, running;
  logic [CNT_W-1:0]         cnt;
  logic [NPIN-1:0]          pins;

  pwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_chan(wr_chan),
    .wr_data(wr_data), .per_buf(per_buf), .cmp_buf(cmp_buf), .cfg(cfg),
    .start_req(start_req), .stop_req(stop_req), .wr_err(wr_err)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .per_buf(per_buf), .cmp_buf(cmp_buf), .running(running), .cnt(cnt),
    .cmp_act(cmp_act)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pwm_pin_out #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst(rst), .running(running), .cnt(cnt),
      .cmp_act(cmp_act[g]), .oe(cfg[g].oe), .stop_lvl(cfg[g].stop_lvl),
      .pin(pins[g])
    );
  end

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];
endmodule

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [1:0]  wr_chan = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err, pwm_a, pwm_b;
  logic        werr_w, wa_w, wb_w;
  int          errs = 0, checks = 0;
  bit          last_err, last_err_w, done = 0;

  always #5 clk = ~clk;

  pwm_edge_gen #(.WIDE_CNT(1'b0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_chan(wr_chan),
    .wr_data(wr_data), .wr_err(wr_err), .pwm_a(pwm_a), .pwm_b(pwm_b));
  pwm_edge_gen #(.WIDE_CNT(1'b1)) uut_w (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_chan(wr_chan),
    .wr_data(wr_data), .wr_err(werr_w), .pwm_a(wa_w), .pwm_b(wb_w));

  function automatic bit pin(input int ch);
    return (ch == 0) ? pwm_a : pwm_b;
  endfunction

  function automatic int exp_cmp(input int per, input int pulse, input bit inv);
    int p = (per == 0) ? 65536 : per;
    if (!inv) return pulse;
    return (p > pulse) ? p - pulse : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] c, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_chan = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_err = wr_err;
    last_err_w = werr_w;
  endtask

  task automatic setup(input int per, input int ch, input int pulse, input bit inv, input bit stl);
    wr(2'd0, 2'd0, 2);
    wr(2'd1, 2'd0, per);
    wr(2'd3, 2'(ch), {29'd0, inv, stl, 1'b1});
    wr(2'd2, 2'(ch), pulse);
    wr(2'd0, 2'd0, 1);
  endtask

  task automatic wait_rise(input int ch, input int lim);
    bit prev = pin(ch);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!prev && pin(ch)) return;
      prev = pin(ch);
    end
  endtask

  // measure one period from a rising edge; optional write issued at sample 2
  task automatic meas(input int ch, input int lim, input bit do_wr,
                      input logic [1:0] a, input logic [1:0] c, input int d,
                      output int hi, output int per);
    bit falling = 0;
    wait_rise(ch, lim);
    hi = 1; per = 1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (do_wr && i == 1) begin wr_en = 1'b1; wr_addr = a; wr_chan = c; wr_data = d; end
      if (do_wr && i == 2) wr_en = 1'b0;
      if (pin(ch) && falling) return;
      if (!pin(ch)) falling = 1;
      else if (!falling) hi++;
      per++;
    end
  endtask

  task automatic hold(input int ch, input bit v, input int n, input string req);
    int bad = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin(ch) != v) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int hi, per, seedv;
    seedv = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(pwm_a == 0 && pwm_b == 0, "R8 reset pins", pwm_a, 0);
    chk(wr_err == 0, "R8 reset err", wr_err, 0);

    // R1 basic
    setup(20, 0, 7, 0, 0);
    meas(0, 200, 0, 0, 0, 0, hi, per);
    chk(hi == 7, "R1 high width", hi, 7);
    chk(per == 20, "R1 period", per, 20);

    // R7 invalid channel, R10 channel B
    wr(2'd3, 2'd1, 1);
    wr(2'd2, 2'd1, 12);
    wr(2'd2, 2'd2, 3);
    chk(last_err == 1, "R7 bad chan err", last_err, 1);
    wr(2'd3, 2'd3, 0);
    chk(last_err == 1, "R7 bad chan cfg err", last_err, 1);
    meas(0, 200, 0, 0, 0, 0, hi, per);
    chk(hi == 7, "R7 pin A unchanged", hi, 7);
    meas(1, 200, 0, 0, 0, 0, hi, per);
    chk(hi == 12 && per == 20, "R10 pin B duty", hi, 12);

    // R6 range rejection, R10 wide accepts
    wr(2'd1, 2'd0, 70000);
    chk(last_err == 1, "R6 period range err", last_err, 1);
    chk(last_err_w == 0, "R10 wide accepts", last_err_w, 0);
    wr(2'd2, 2'd0, 70000);
    chk(last_err == 1, "R6 duty range err", last_err, 1);
    meas(0, 200, 0, 0, 0, 0, hi, per);
    meas(0, 200, 0, 0, 0, 0, hi, per);
    chk(hi == 7 && per == 20, "R6 values kept", per, 20);

    // R4 shadow loading
    setup(40, 0, 10, 0, 0);
    meas(0, 400, 1, 2'd1, 2'd0, 30, hi, per);
    chk(hi == 10 && per == 40, "R4 cycle in progress keeps period", per, 40);
    meas(0, 400, 1, 2'd2, 2'd0, 25, hi, per);
    chk(hi == 10 && per == 30, "R4 new period next cycle", per, 30);
    meas(0, 400, 1, 2'd0, 2'd0, 1, hi, per);
    chk(hi == 25 && per == 30, "R4 new duty next cycle", hi, 25);
    chk(hi == 25 && per == 30, "R9 start while running ignored", per, 30);

    // R9 stop mid-run, restart
    wr(2'd0, 2'd0, 2);
    hold(0, 0, 40, "R9 stopped holds stop level");
    wr(2'd0, 2'd0, 3);
    hold(0, 0, 40, "R9 stop beats start");
    wr(2'd0, 2'd0, 1);
    @(negedge clk);
    chk(pwm_a == 1, "R9 start begins at count 0", pwm_a, 1);

    // R8 stop level and output enable
    wr(2'd0, 2'd0, 2);
    wr(2'd3, 2'd0, 3);
    hold(0, 1, 10, "R8 stop level high while stopped");
    wr(2'd3, 2'd0, 0);
    wr(2'd0, 2'd0, 1);
    hold(0, 0, 70, "R8 oe clear holds stop level");

    // R3 / R5 directed corners
    setup(20, 0, 25, 1, 0);
    hold(0, 0, 45, "R5 saturating inverted compare low");
    setup(20, 0, 0, 1, 0);
    hold(0, 1, 45, "R3 compare at period stays high");
    setup(20, 1, 0, 0, 0);
    hold(1, 0, 45, "R3 compare zero stays low");
    setup(20, 0, 6, 1, 0);
    meas(0, 200, 0, 0, 0, 0, hi, per);
    chk(hi == 14 && per == 20, "R5 inverted width", hi, 14);

    // random mix
    for (int t = 0; t < 16; t++) begin
      int p = $urandom_range(50, 3);
      int pl = $urandom_range(p + 3, 0);
      bit iv = 1'($urandom_range(1, 0));
      int ch = $urandom_range(1, 0);
      int c = exp_cmp(p, pl, iv);
      setup(p, ch, pl, iv, 0);
      if (c == 0) hold(ch, 0, 2 * p + 4, "R3 random low");
      else if (c >= p) hold(ch, 1, 2 * p + 4, "R3 random high");
      else begin
        meas(ch, 400, 0, 0, 0, 0, hi, per);
        chk(hi == c && per == p, iv ? "R5 random inverted" : "R1 random", hi, c);
      end
    end

    // R2 full range
    wr(2'd0, 2'd0, 2);
    wr(2'd3, 2'd0, 1);
    setup(0, 0, 65530, 0, 0);
    begin
      int h = 0, n = 0;
      bit falling = 0;
      for (int i = 0; i < 70000; i++) begin
        @(negedge clk);
        if (pin(0) && falling) break;
        if (!pin(0)) falling = 1;
        else if (!falling) h++;
        n++;
      end
      chk(h == 65530, "R2 full range high", h, 65530);
      chk(n == 65536, "R2 full range period", n, 65536);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule